// File: doc/BRIEF.md
# Fuzzy Rule Inference Sequencer

This block evaluates a two-input fuzzy rule base that sits in an external byte-wide RAM. Software first loads the membership degrees of the two input variables into two small on-chip register banks through a write port. A start pulse then makes the block walk the rule list. For each rule it fetches three bytes over a RAM read port that handshakes with a ready input. It looks up the two selected input degrees and combines them into a rule strength. It then folds that strength into one of eight output degrees.

Three combination methods are available. Max-min takes the minimum of the two degrees as the strength and aggregates by maximum. Max-product takes the top half of the product and aggregates by maximum. Sum-product takes the top half of the product and aggregates by a saturating sum. When the last rule has been applied a done flag rises, and the eight output degrees can be read through a select input.

Top module: `fuzzy_rule_seq`

## Requirements
- R1: After reset, `done` and `busy` are 0, both RAM strobes (`ram_ce_n`, `ram_rd_n`) are 1, and every output degree reads 0.
- R2: Rule n takes the three RAM bytes at `rule_base + 3n`, `+3n+1` and `+3n+2`, fetched in ascending address order. They hold, in that order, the variable-1 function index i, the variable-2 function index j and the output index k. Each index is taken from bits [2:0] of its byte and the upper bits are ignored. Both strobes are low together, and only while a fetch is waiting.
- R3: While a fetch is pending and `ram_ready` is 0, the address and strobes hold. A byte is consumed only on a clock edge with `ram_ready` = 1. Any stall pattern gives the same result as no stall.
- R4: Method code 0, or code 3, selects max-min: strength = min(d1[i], d2[j]), and out[k] = max(out[k], strength).
- R5: Method code 1 selects sum-product: strength = (d1[i]·d2[j]) >> 8, and out[k] = min(255, out[k] + strength).
- R6: Method code 2 selects max-product: strength = (d1[i]·d2[j]) >> 8, and out[k] = max(out[k], strength).
- R7: A start that is accepted clears all eight output degrees to 0.
- R8: `done` rises after the last rule is applied. It stays high, with the output degrees unchanged and no RAM access, until the next start is accepted. `busy` is high from start to completion.
- R9: A rule count of 0 raises `done` on the clock edge that samples start, with no RAM read.
- R10: A start that arrives while `busy` is 1 is ignored, and the running evaluation completes with its original method, count and base.
- R11: A write with `deg_we` = 1 stores `deg_val` into entry `deg_idx` of the bank chosen by `deg_var` (0 = variable 1, 1 = variable 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an evaluation (accepted only when idle) |
| method | input | 2 | Inference method code, latched at start |
| rule_count | input | 8 | Number of rules, latched at start |
| rule_base | input | 13 | RAM address of rule 0, latched at start |
| deg_we | input | 1 | Input degree write enable |
| deg_var | input | 1 | Bank select for the degree write |
| deg_idx | input | 3 | Membership function index for the degree write |
| deg_val | input | 8 | Degree value to write |
| out_sel | input | 3 | Output degree select |
| out_deg | output | 8 | Selected output degree |
| ram_addr | output | 13 | RAM byte address |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_rd_n | output | 1 | RAM read strobe, active low |
| ram_data | input | 8 | RAM read data |
| ram_ready | input | 1 | RAM data valid for the pending read |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | Evaluation complete |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of a running rule walk. The bench raises start a few cycles after launching an eight-rule evaluation, with a count and method that would clearly change the outcome. It then checks that the read count and the output degrees match the first request. A second hard case is the sum-product saturation. To reach it, the bench places several rules on the same output index whose inputs both have degree 255, so the running sum passes 255. The bench RAM model can also withhold `ram_ready` on three cycles out of four, which keeps many fetches waiting while the address is watched for movement.

// File: rtl/fzr_pkg.sv
package fzr_pkg;

    localparam logic [1:0] METH_MAXMIN  = 2'd0;
    localparam logic [1:0] METH_SUMPROD = 2'd1;
    localparam logic [1:0] METH_MAXPROD = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_APPLY = 2'd2
    } seq_state_e;

endpackage

// File: rtl/fzr_degree_bank.sv
module fzr_degree_bank #(
    parameter int DW  = 8,
    parameter int NFN = 8,
    localparam int FW = $clog2(NFN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [FW-1:0] wr_idx,
    input  logic [DW-1:0] wr_val,
    input  logic [FW-1:0] rd_idx,
    output logic [DW-1:0] rd_val
);

    logic [DW-1:0] deg_d [NFN];
    logic [DW-1:0] deg_q [NFN];

    always_comb begin
        deg_d = deg_q;
        if (wr_en) begin
            deg_d[wr_idx] = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            deg_q <= '{default: '0};
        end else begin
            deg_q <= deg_d;
        end
    end

    assign rd_val = deg_q[rd_idx];

endmodule

// File: rtl/fzr_combine.sv
module fzr_combine
    import fzr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [1:0]    method,
    input  logic [DW-1:0] deg_a,
    input  logic [DW-1:0] deg_b,
    input  logic [DW-1:0] prev,
    output logic [DW-1:0] merged
);

    logic [2*DW-1:0] prod;
    logic [DW-1:0]   strength;
    logic [DW:0]     sum;

    always_comb begin
        prod = deg_a * deg_b;
        if (method == METH_SUMPROD || method == METH_MAXPROD) begin
            strength = prod[2*DW-1:DW];
        end else begin
            strength = (deg_a < deg_b) ? deg_a : deg_b;
        end
        sum = {1'b0, prev} + {1'b0, strength};
        if (method == METH_SUMPROD) begin
            merged = sum[DW] ? {DW{1'b1}} : sum[DW-1:0];
        end else begin
            merged = (strength > prev) ? strength : prev;
        end
    end

endmodule

// File: rtl/fzr_out_bank.sv
module fzr_out_bank #(
    parameter int DW  = 8,
    parameter int NFN = 8,
    localparam int FW = $clog2(NFN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          upd_en,
    input  logic [FW-1:0] upd_idx,
    input  logic [DW-1:0] upd_val,
    output logic [DW-1:0] cur_val,
    input  logic [FW-1:0] rd_idx,
    output logic [DW-1:0] rd_val
);

    logic [DW-1:0] acc_d [NFN];
    logic [DW-1:0] acc_q [NFN];

    always_comb begin
        acc_d = acc_q;
        if (clear) begin
            acc_d = '{default: '0};
        end else if (upd_en) begin
            acc_d[upd_idx] = upd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '{default: '0};
        end else begin
            acc_q <= acc_d;
        end
    end

    assign cur_val = acc_q[upd_idx];
    assign rd_val  = acc_q[rd_idx];

endmodule

// File: rtl/fuzzy_rule_seq.sv
module fuzzy_rule_seq
    import fzr_pkg::*;
#(
    parameter int DW  = 8,
    parameter int AW  = 13,
    parameter int RW  = 8,
    parameter int NFN = 8,
    parameter int CW  = 8,
    localparam int FW = $clog2(NFN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    method,
    input  logic [CW-1:0] rule_count,
    input  logic [AW-1:0] rule_base,
    input  logic          deg_we,
    input  logic          deg_var,
    input  logic [FW-1:0] deg_idx,
    input  logic [DW-1:0] deg_val,
    input  logic [FW-1:0] out_sel,
    output logic [DW-1:0] out_deg,
    output logic [AW-1:0] ram_addr,
    output logic          ram_ce_n,
    output logic          ram_rd_n,
    input  logic [RW-1:0] ram_data,
    input  logic          ram_ready,
    output logic          busy,
    output logic          done
);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] rule;
        logic [1:0]    fld;
        logic [AW-1:0] addr;
        logic [FW-1:0] fi;
        logic [FW-1:0] fj;
        logic [FW-1:0] fk;
        logic [CW-1:0] cnt;
        logic [1:0]    meth;
        logic          done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic clr_out;
    logic upd_out;
    logic [CW:0]   rule_inc;
    logic [DW-1:0] deg_rd [2];
    logic [DW-1:0] acc_cur;
    logic [DW-1:0] acc_new;

    // Two input degree banks, selected by deg_var
    for (genvar g = 0; g < 2; g++) begin : g_var
        fzr_degree_bank #(.DW(DW), .NFN(NFN)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (deg_we && (deg_var == 1'(g))),
            .wr_idx (deg_idx),
            .wr_val (deg_val),
            .rd_idx ((g == 0) ? seq_q.fi : seq_q.fj),
            .rd_val (deg_rd[g])
        );
    end

    fzr_combine #(.DW(DW)) u_combine (
        .method (seq_q.meth),
        .deg_a  (deg_rd[0]),
        .deg_b  (deg_rd[1]),
        .prev   (acc_cur),
        .merged (acc_new)
    );

    fzr_out_bank #(.DW(DW), .NFN(NFN)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clr_out),
        .upd_en  (upd_out),
        .upd_idx (seq_q.fk),
        .upd_val (acc_new),
        .cur_val (acc_cur),
        .rd_idx  (out_sel),
        .rd_val  (out_deg)
    );

    assign rule_inc = {1'b0, seq_q.rule} + (CW+1)'(1);

    always_comb begin
        seq_d   = seq_q;
        clr_out = 1'b0;
        upd_out = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    clr_out    = 1'b1;
                    seq_d.cnt  = rule_count;
                    seq_d.meth = method;
                    seq_d.addr = rule_base;
                    seq_d.rule = '0;
                    seq_d.fld  = '0;
                    if (rule_count == '0) begin
                        seq_d.done = 1'b1;
                        seq_d.st   = ST_IDLE;
                    end else begin
                        seq_d.done = 1'b0;
                        seq_d.st   = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (ram_ready) begin
                    seq_d.addr = seq_q.addr + AW'(1);
                    case (seq_q.fld)
                        2'd0:    seq_d.fi = ram_data[FW-1:0];
                        2'd1:    seq_d.fj = ram_data[FW-1:0];
                        default: seq_d.fk = ram_data[FW-1:0];
                    endcase
                    if (seq_q.fld == 2'd2) begin
                        seq_d.fld = '0;
                        seq_d.st  = ST_APPLY;
                    end else begin
                        seq_d.fld = seq_q.fld + 2'd1;
                    end
                end
            end
            ST_APPLY: begin
                upd_out    = 1'b1;
                seq_d.rule = rule_inc[CW-1:0];
                if (rule_inc == {1'b0, seq_q.cnt}) begin
                    seq_d.done = 1'b1;
                    seq_d.st   = ST_IDLE;
                end else begin
                    seq_d.st   = ST_FETCH;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ram_addr = seq_q.addr;
    assign ram_ce_n = (seq_q.st != ST_FETCH);
    assign ram_rd_n = (seq_q.st != ST_FETCH);
    assign busy     = (seq_q.st != ST_IDLE);
    assign done     = seq_q.done;

endmodule

// File: rtl/fzr_checker.sv
module fzr_checker #(
    parameter int AW = 13,
    parameter int DW = 8,
    parameter int FW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          ram_ce_n,
    input logic          ram_rd_n,
    input logic          ram_ready,
    input logic [AW-1:0] ram_addr,
    input logic [FW-1:0] out_sel,
    input logic [DW-1:0] out_deg
);

    // R2: both strobes move together
    assert_strobe_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_ce_n == ram_rd_n);

    // R3: a waiting fetch keeps its address and strobe
    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_ce_n && !ram_ready) |=> ($stable(ram_addr) && !ram_ce_n));

    // R8: no RAM traffic and not busy once complete
    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ram_ce_n && !busy));

    // R8: completion flag holds until a new start
    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R8: results frozen while complete and no new start
    assert_result_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(out_deg) || !$stable(out_sel)));

endmodule

bind fuzzy_rule_seq fzr_checker #(.AW(AW), .DW(DW), .FW(FW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .ram_ce_n  (ram_ce_n),
    .ram_rd_n  (ram_rd_n),
    .ram_ready (ram_ready),
    .ram_addr  (ram_addr),
    .out_sel   (out_sel),
    .out_deg   (out_deg)
);

// File: tb/sim_fuzzy_rule_seq.sv
`timescale 1ns/1ps
module sim_fuzzy_rule_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  method = 2'd0;
    logic [7:0]  rule_count = 8'd0;
    logic [12:0] rule_base = 13'd0;
    logic        deg_we = 1'b0;
    logic        deg_var = 1'b0;
    logic [2:0]  deg_idx = 3'd0;
    logic [7:0]  deg_val = 8'd0;
    logic [2:0]  out_sel = 3'd0;
    logic [7:0]  out_deg;
    logic [12:0] ram_addr;
    logic        ram_ce_n, ram_rd_n;
    logic [7:0]  ram_data;
    logic        ram_ready;
    logic        busy, done;

    logic [7:0]  mem [64];
    int          d1 [8];
    int          d2 [8];
    int          expv [8];
    bit          stall_on = 1'b0;
    logic [1:0]  rdy_cnt = 2'd0;

    int          n_chk = 0;
    int          n_fail = 0;
    int          nrd = 0;
    int          nce = 0;
    int          stall_err = 0;
    int          rlog [256];
    bit          prev_wait = 1'b0;
    logic [12:0] prev_addr = '0;

    always #5 clk = ~clk;

    fuzzy_rule_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .method(method),
        .rule_count(rule_count), .rule_base(rule_base),
        .deg_we(deg_we), .deg_var(deg_var), .deg_idx(deg_idx), .deg_val(deg_val),
        .out_sel(out_sel), .out_deg(out_deg),
        .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_rd_n(ram_rd_n),
        .ram_data(ram_data), .ram_ready(ram_ready), .busy(busy), .done(done)
    );

    // RAM model: data always presented, ready optionally thinned out
    assign ram_data  = mem[ram_addr[5:0]];
    assign ram_ready = !stall_on || (rdy_cnt == 2'd0);
    always @(negedge clk) rdy_cnt <= rdy_cnt + 2'd1;

    // Bus monitor
    always @(posedge clk) begin
        if (rst_n) begin
            if (!ram_ce_n && ram_ready) begin
                rlog[nrd % 256] = int'(ram_addr);
                nrd++;
            end
            if (!ram_ce_n) nce++;
            if (prev_wait && ram_addr != prev_addr) stall_err++;
            prev_wait = !ram_ce_n && !ram_ready;
            prev_addr = ram_addr;
        end
    end

    task automatic chk(input string req, input int act, input int exp_v, input string what);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    task automatic wr_deg(input int v, input int idx, input int val);
        @(negedge clk);
        deg_we = 1'b1; deg_var = v[0]; deg_idx = idx[2:0]; deg_val = val[7:0];
        @(negedge clk);
        deg_we = 1'b0;
        if (v == 0) d1[idx] = val; else d2[idx] = val;
    endtask

    task automatic set_rule(input int base, input int n, input int i, input int j, input int k);
        mem[base + 3*n]     = 8'hA8 | 8'(i);
        mem[base + 3*n + 1] = 8'h50 | 8'(j);
        mem[base + 3*n + 2] = 8'hF8 | 8'(k);
    endtask

    task automatic model(input int m, input int cnt, input int base);
        for (int k = 0; k < 8; k++) expv[k] = 0;
        for (int r = 0; r < cnt; r++) begin
            int i, j, k, a, b, s;
            i = mem[base + 3*r] & 7;
            j = mem[base + 3*r + 1] & 7;
            k = mem[base + 3*r + 2] & 7;
            a = d1[i]; b = d2[j];
            if (m == 1 || m == 2) s = (a * b) / 256;
            else s = (a < b) ? a : b;
            if (m == 1) expv[k] = (expv[k] + s > 255) ? 255 : expv[k] + s;
            else if (s > expv[k]) expv[k] = s;
        end
    endtask

    task automatic check_outs(input string req);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            out_sel = 3'(k);
            #1;
            chk(req, int'(out_deg), expv[k], $sformatf("out_deg[%0d]", k));
        end
    endtask

    task automatic wait_done(input string req);
        int w = 0;
        while (!done && w < 5000) begin
            @(negedge clk);
            w++;
        end
        chk(req, int'(done), 1, "done after rule walk");
    endtask

    // Launch, wait, and compare; optional start pulse mid-run (R10)
    task automatic run_seq(input int m, input int cnt, input int base, input bit stl,
                           input bit poke, input string req);
        int rd0, st0;
        stall_on = stl;
        @(negedge clk);
        method = m[1:0]; rule_count = cnt[7:0]; rule_base = 13'(base); start = 1'b1;
        rd0 = nrd; st0 = stall_err;
        @(negedge clk);
        start = 1'b0;
        chk("R8", int'(busy && !done), 1, "busy set and done cleared after start");
        if (poke) begin
            repeat (5) @(negedge clk);
            method = 2'd1; rule_count = 8'd0; rule_base = 13'd40; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(req);
        model(m, cnt, base);
        check_outs(req);
        chk("R2", nrd - rd0, 3*cnt, "RAM bytes read");
        begin
            int bad = 0;
            for (int q = 0; q < 3*cnt; q++)
                if (rlog[(rd0 + q) % 256] != base + q) bad++;
            chk("R2", bad, 0, "out-of-order read addresses");
        end
        chk("R3", stall_err - st0, 0, "address moves while waiting");
        stall_on = 1'b0;
    endtask

    task automatic t_reset();
        int nz = 0;
        chk("R1", int'(done), 0, "done after reset");
        chk("R1", int'(busy), 0, "busy after reset");
        chk("R1", int'(ram_ce_n && ram_rd_n), 1, "strobes idle after reset");
        for (int k = 0; k < 8; k++) begin
            out_sel = 3'(k);
            #1;
            if (out_deg != 0) nz++;
        end
        chk("R1", nz, 0, "nonzero output degrees after reset");
    endtask

    task automatic t_zero_count();
        int ce0;
        ce0 = nce;
        @(negedge clk);
        rule_count = 8'd0; start = 1'b1;
        @(posedge clk);
        #1;
        chk("R9", int'(done && !busy), 1, "done on start edge with zero rules");
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9", nce - ce0, 0, "RAM cycles for zero rules");
        for (int k = 0; k < 8; k++) expv[k] = 0;
        check_outs("R7");
    endtask

    task automatic t_hold();
        int snap [8];
        for (int k = 0; k < 8; k++) snap[k] = expv[k];
        repeat (30) @(negedge clk);
        chk("R8", int'(done), 1, "done still held");
        for (int k = 0; k < 8; k++) expv[k] = snap[k];
        check_outs("R8");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < 64; a++) mem[a] = 8'h00;
        for (int k = 0; k < 8; k++) begin d1[k] = 0; d2[k] = 0; end
        // Rule set A at base 0: mixed indices, repeated outputs
        set_rule(0, 0, 1, 2, 3);
        set_rule(0, 1, 3, 1, 3);
        set_rule(0, 2, 5, 0, 0);
        set_rule(0, 3, 6, 6, 7);
        set_rule(0, 4, 2, 3, 1);
        set_rule(0, 5, 4, 4, 3);
        set_rule(0, 6, 7, 7, 6);
        set_rule(0, 7, 0, 5, 2);
        // Rule set B at base 30: all heavy rules hitting output 5
        for (int r = 0; r < 6; r++) set_rule(30, r, 6, 0, 5);
        set_rule(30, 6, 2, 1, 4);
        set_rule(30, 7, 5, 2, 5);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();

        // R11: load both banks
        begin
            int v1 [8] = '{0, 40, 90, 130, 180, 220, 255, 17};
            int v2 [8] = '{255, 200, 150, 100, 60, 30, 0, 240};
            for (int k = 0; k < 8; k++) begin
                wr_deg(0, k, v1[k]);
                wr_deg(1, k, v2[k]);
            end
        end

        run_seq(0, 8, 0,  1'b0, 1'b0, "R4");   // max-min, also covers R11 lookups
        run_seq(1, 8, 30, 1'b0, 1'b0, "R5");   // sum-product with saturation
        out_sel = 3'd5;
        #1;
        chk("R5", int'(out_deg), 255, "saturated sum");
        run_seq(2, 8, 0,  1'b0, 1'b0, "R6");   // max-product
        run_seq(3, 8, 0,  1'b0, 1'b0, "R4");   // code 3 behaves as max-min
        run_seq(0, 8, 0,  1'b1, 1'b0, "R3");   // stalled RAM
        t_hold();                              // R8
        t_zero_count();                        // R9 and R7
        run_seq(2, 8, 30, 1'b0, 1'b1, "R10");  // start while busy ignored
        wr_deg(1, 0, 10);                      // R11: rewrite one entry
        run_seq(1, 8, 30, 1'b0, 1'b0, "R11");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule